// File: doc/BRIEF.md
# Set-Associative Page Translation Buffer

This block holds a small number of recent page translations next to the address path. A lookup presents an 8-bit virtual page number and gets back, in the same cycle, a hit flag, the physical page number and the permission bits of the stored entry. The page number is split in two. The low bits choose one of four sets. The high bits form a tag, and the tag is compared against all four ways of the chosen set in parallel.

After a miss, a table walker outside the block installs the missing translation through the fill port. The fill goes first to a way that already holds the same tag, and then to a free way. When neither exists, a round-robin pointer kept for each set chooses the victim. A flush input clears every entry at once. Out of reset the buffer holds a small fixed set of translations, so lookups can hit before any fill has been made.

Top module: `page_xlat_cache`

## Requirements
- R1: The set index is `vpn[1:0]` and the tag is `vpn[7:2]`, so virtual address bits 7:6 select the set and bits 13:8 form the tag. A lookup result depends only on the current lookup input and the stored state, with no clock delay.
- R2: A lookup hits only when a way in the indexed set is valid and its tag equals the lookup tag. On a hit, `lk_ppn` and `lk_perm` carry that way's stored values. On a miss, `lk_hit`, `lk_ppn` and `lk_perm` are all zero.
- R3: After reset the valid entries are exactly these (set/tag -> PPN), each with permissions 2'b01:
  - set 0 tag 0x09 -> 0x0D
  - set 0 tag 0x07 -> 0x02
  - set 1 tag 0x03 -> 0x2D
  - set 3 tag 0x03 -> 0x0D
  - set 3 tag 0x0A -> 0x34

  Every other way is invalid, and every round-robin pointer is 0.
- R4: After reset, virtual address 0x03D4 (VPN 0x0F) hits with PPN 0x0D, and virtual address 0x0B8F (VPN 0x2E) misses.
- R5: A fill whose tag matches no valid way of its set writes the lowest-numbered invalid way of that set. The new entry is visible to lookups from the cycle after the fill.
- R6: A fill into a set with no invalid way and no matching tag replaces the way named by that set's pointer. The pointer then advances by one and wraps from 3 to 0. No other event moves a pointer.
- R7: A fill whose tag matches a valid way of its set overwrites that way. It does not create a second entry, and the set's other entries are unchanged.
- R8: A flush makes every entry invalid from the next cycle. A fill in the same cycle as a flush has no effect on the entries or the pointers.
- R9: A fill stores the given PPN and the 2-bit permission field unchanged, and a later lookup returns both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, loads the boot entries |
| lk_vpn | input | 8 | Lookup virtual page number |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | 6 | Physical page number of the hit entry, zero on a miss |
| lk_perm | output | 2 | Permission bits of the hit entry, zero on a miss |
| fl_en | input | 1 | Install a translation this cycle |
| fl_vpn | input | 8 | Virtual page number being installed |
| fl_ppn | input | 6 | Physical page number being installed |
| fl_perm | input | 2 | Permission bits being installed |
| flush | input | 1 | Invalidate every entry |

## Verification
The assertions check three things on every cycle:
- no lookup ever matches more than one way, which is the no-duplicate property of tag-matching fills;
- a flush leaves no valid entry behind;
- pointers hold still whenever no fill is made, and a fill that is not flushed never lowers the number of valid entries.

Only the bench scenarios can show which way a fill picks and the order of round-robin eviction. They can also show that a flush beats a simultaneous fill and that the boot contents are correct. To cover this, the bench sweeps all 256 page numbers against its own model after reset and after each fill pattern.

// File: rtl/page_xlat_cache.sv
module page_xlat_cache #(
  parameter int VPN_W  = 8,
  parameter int PPN_W  = 6,
  parameter int PERM_W = 2,
  parameter int SETS   = 4,
  parameter int WAYS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              lk_hit,
  output logic [PPN_W-1:0]  lk_ppn,
  output logic [PERM_W-1:0] lk_perm,
  input  logic              fl_en,
  input  logic [VPN_W-1:0]  fl_vpn,
  input  logic [PPN_W-1:0]  fl_ppn,
  input  logic [PERM_W-1:0] fl_perm,
  input  logic              flush
);
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = VPN_W - SET_W;
  localparam int BOOT_W = 1 + TAG_W + PPN_W;

  logic [SETS-1:0][WAYS-1:0] vld;
  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic [PPN_W-1:0]  ppn_q  [SETS][WAYS];
  logic [PERM_W-1:0] perm_q [SETS][WAYS];
  logic [WAY_W-1:0]  ptr_q  [SETS];

  function automatic logic [BOOT_W-1:0] boot_entry(int s, int w);
    if (SETS != 4 || WAYS != 4) return '0;
    case (s * 4 + w)
      1:       return {1'b1, TAG_W'(9),  PPN_W'(13)};
      3:       return {1'b1, TAG_W'(7),  PPN_W'(2)};
      4:       return {1'b1, TAG_W'(3),  PPN_W'(45)};
      13:      return {1'b1, TAG_W'(3),  PPN_W'(13)};
      14:      return {1'b1, TAG_W'(10), PPN_W'(52)};
      default: return '0;
    endcase
  endfunction

  wire [SET_W-1:0] lk_set = lk_vpn[SET_W-1:0];
  wire [TAG_W-1:0] lk_tag = lk_vpn[VPN_W-1:SET_W];
  wire [SET_W-1:0] fl_set = fl_vpn[SET_W-1:0];
  wire [TAG_W-1:0] fl_tag = fl_vpn[VPN_W-1:SET_W];

  logic [WAYS-1:0] lk_match;
  always_comb begin
    lk_ppn  = '0;
    lk_perm = '0;
    for (int w = 0; w < WAYS; w++) begin
      lk_match[w] = vld[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
      if (lk_match[w]) begin
        lk_ppn  = lk_ppn  | ppn_q[lk_set][w];
        lk_perm = lk_perm | perm_q[lk_set][w];
      end
    end
  end
  assign lk_hit = |lk_match;

  logic [WAYS-1:0]  fl_same, fl_free;
  logic [WAY_W-1:0] same_way, free_way, fl_way;
  always_comb begin
    same_way = '0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      fl_same[w] = vld[fl_set][w] && (tag_q[fl_set][w] == fl_tag);
      fl_free[w] = !vld[fl_set][w];
      if (fl_same[w]) same_way = WAY_W'(w);
      if (fl_free[w]) free_way = WAY_W'(w);
    end
    if (|fl_same)      fl_way = same_way;
    else if (|fl_free) fl_way = free_way;
    else               fl_way = ptr_q[fl_set];
  end

  wire do_fill  = fl_en && !flush;
  wire do_evict = do_fill && !(|fl_same) && !(|fl_free);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        ptr_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          {vld[s][w], tag_q[s][w], ppn_q[s][w]} <= boot_entry(s, w);
          perm_q[s][w] <= PERM_W'(boot_entry(s, w)[BOOT_W-1]);
        end
      end
    end else if (flush) begin
      vld <= '0;
    end else if (do_fill) begin
      vld[fl_set][fl_way]    <= 1'b1;
      tag_q[fl_set][fl_way]  <= fl_tag;
      ppn_q[fl_set][fl_way]  <= fl_ppn;
      perm_q[fl_set][fl_way] <= fl_perm;
      if (do_evict)
        ptr_q[fl_set] <= (ptr_q[fl_set] == WAY_W'(WAYS - 1)) ? '0 : ptr_q[fl_set] + 1'b1;
    end
  end

  p_single_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));
  p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld == '0));
  p_fill_keeps_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_en && !flush) |=> ($countones(vld) >= $past($countones(vld))));
  p_ptr_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_en |=> (ptr_q[0] == $past(ptr_q[0]) && ptr_q[SETS-1] == $past(ptr_q[SETS-1])));
endmodule

// File: tb/sim_page_xlat_cache.sv
module sim_page_xlat_cache;
  logic clk = 0, rst_n = 0;
  logic [7:0] lk_vpn = 0, fl_vpn = 0;
  logic [5:0] fl_ppn = 0, lk_ppn;
  logic [1:0] fl_perm = 0, lk_perm;
  logic fl_en = 0, flush = 0, lk_hit;
  int total = 0, bad = 0;

  bit       mv  [4][4];
  bit [5:0] mt  [4][4];
  bit [5:0] mp  [4][4];
  bit [1:0] mr  [4][4];
  int       mptr[4];

  always #4 clk = ~clk;

  page_xlat_cache u0 (.clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn), .lk_hit(lk_hit),
    .lk_ppn(lk_ppn), .lk_perm(lk_perm), .fl_en(fl_en), .fl_vpn(fl_vpn),
    .fl_ppn(fl_ppn), .fl_perm(fl_perm), .flush(flush));

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic model_boot();
    for (int s = 0; s < 4; s++) begin
      mptr[s] = 0;
      for (int w = 0; w < 4; w++) begin mv[s][w] = 0; mt[s][w] = 0; mp[s][w] = 0; mr[s][w] = 0; end
    end
    mv[0][1] = 1; mt[0][1] = 6'h09; mp[0][1] = 6'h0D; mr[0][1] = 2'b01;
    mv[0][3] = 1; mt[0][3] = 6'h07; mp[0][3] = 6'h02; mr[0][3] = 2'b01;
    mv[1][0] = 1; mt[1][0] = 6'h03; mp[1][0] = 6'h2D; mr[1][0] = 2'b01;
    mv[3][1] = 1; mt[3][1] = 6'h03; mp[3][1] = 6'h0D; mr[3][1] = 2'b01;
    mv[3][2] = 1; mt[3][2] = 6'h0A; mp[3][2] = 6'h34; mr[3][2] = 2'b01;
  endtask

  task automatic sweep(string req);
    for (int v = 0; v < 256; v++) begin
      logic h; logic [5:0] p; logic [1:0] r;
      h = 0; p = 0; r = 0;
      for (int w = 0; w < 4; w++)
        if (mv[v % 4][w] && mt[v % 4][w] == 6'(v / 4)) begin h = 1; p = mp[v % 4][w]; r = mr[v % 4][w]; end
      lk_vpn = 8'(v);
      #1;
      check(req, {7'd0, lk_hit, lk_ppn, lk_perm}, {7'd0, h, p, r});
    end
  endtask

  task automatic fill(logic [7:0] vpn, logic [5:0] ppn, logic [1:0] perm, logic fl_with_flush);
    int s, way;
    s = vpn % 4;
    @(negedge clk);
    fl_en = 1; fl_vpn = vpn; fl_ppn = ppn; fl_perm = perm; flush = fl_with_flush;
    @(posedge clk);
    #1;
    fl_en = 0; flush = 0;
    if (fl_with_flush) begin
      for (int a = 0; a < 4; a++) for (int b = 0; b < 4; b++) mv[a][b] = 0;
    end else begin
      way = -1;
      for (int w = 0; w < 4; w++) if (way < 0 && mv[s][w] && mt[s][w] == vpn[7:2]) way = w;
      for (int w = 0; w < 4; w++) if (way < 0 && !mv[s][w]) way = w;
      if (way < 0) begin way = mptr[s]; mptr[s] = (mptr[s] + 1) % 4; end
      mv[s][way] = 1; mt[s][way] = vpn[7:2]; mp[s][way] = ppn; mr[s][way] = perm;
    end
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    model_boot();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    sweep("R3 boot contents");
    lk_vpn = 8'(16'h03D4 >> 6); #1;
    check("R4 va 0x03D4 hit", {7'd0, lk_hit, lk_ppn, 2'b00}, {7'd0, 1'b1, 6'h0D, 2'b00});
    lk_vpn = 8'(16'h0B8F >> 6); #1;
    check("R4 va 0x0B8F miss", {15'd0, lk_hit}, 16'd0);
    fill(8'h2E, 6'h15, 2'b11, 0);
    sweep("R5 R9 fill into empty set 2");
    fill({6'h11, 2'd0}, 6'h21, 2'b10, 0);
    fill({6'h12, 2'd0}, 6'h22, 2'b00, 0);
    sweep("R5 lowest free way in set 0");
    fill({6'h13, 2'd0}, 6'h23, 2'b01, 0);
    fill({6'h14, 2'd0}, 6'h24, 2'b11, 0);
    lk_vpn = {6'h11, 2'd0}; #1;
    check("R6 first round-robin victim way 0", {15'd0, lk_hit}, 16'd0);
    lk_vpn = {6'h09, 2'd0}; #1;
    check("R6 second round-robin victim way 1", {15'd0, lk_hit}, 16'd0);
    for (int k = 0; k < 6; k++) fill({6'(6'h20 + k), 2'd0}, 6'(k), 2'(k), 0);
    sweep("R6 pointer wraps in set 0");
    fill(8'h0F, 6'h2A, 2'b11, 0);
    sweep("R7 R2 overwrite matching tag in set 3");
    fill(8'h55, 6'h3F, 2'b11, 1);
    sweep("R8 flush wins over fill");
    fill(8'h77, 6'h31, 2'b10, 0);
    fill(8'h7B, 6'h32, 2'b01, 0);
    sweep("R1 R5 fills after flush");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule